// File: doc/BRIEF.md
# Burst Address Sequencer

This block is the synchronous address front end of a pipelined burst static RAM. On every rising clock edge it samples a 15-bit external word address and two burst-start strobes. One strobe belongs to the processor side and one to the controller side. It also samples an advance strobe, three chip enables and a combined active-low write flag. From these it decides whether the cycle deselects the array, begins a burst, continues a burst or suspends a burst.

The outputs are registered and hold the state decided at the last edge. They are the internal word address, a valid flag and a write indication. The upper address bits stay as loaded for the whole burst. The two lowest bits come from a 2-bit burst count. A static mode input picks how that count is applied: an interleaved XOR or a linear increment that wraps modulo 4.

A deselect is sticky. Continue and suspend cycles cannot revive the block, and only a new burst start makes it valid again.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset `valid_o` is 0, `write_o` is 0 and `addr_o` is 0.
- R2: The chip counts as selected only when `cs_n_i`=0, `cs_hi_i`=1 and `cs2_n_i`=0. A controller start (`start_cpu_n_i`=1, `start_ctl_n_i`=0, `cs_n_i`=0) without that selection deselects the block: `valid_o`=0 and `write_o`=0 after the edge.
- R3: With `cs_n_i`=0 and `start_cpu_n_i`=0, the cycle begins a read at `addr_i`. This holds whatever `wr_n_i` and `start_ctl_n_i` are, so `valid_o`=1, `write_o`=0 and `addr_o`=`addr_i`. If `cs_hi_i`=0 or `cs2_n_i`=1 in such a cycle, the cycle is a deselect instead.
- R4: With `cs_n_i`=1 and `start_ctl_n_i`=0, the cycle deselects. With `cs_n_i`=1, `start_cpu_n_i` starts no burst.
- R5: A selected controller start begins a burst at `addr_i` with `write_o` = NOT `wr_n_i`.
- R6: With `start_ctl_n_i`=1 and either `start_cpu_n_i`=1 or `cs_n_i`=1, an active block moves to the next burst address when `adv_n_i`=0. It keeps the current address when `adv_n_i`=1. The chip enables are ignored in both cases.
- R7: With `mode_i`=1 (interleaved), the k-th burst address has low bits equal to the loaded low bits XOR k.
- R8: With `mode_i`=0 (linear), the k-th burst address has low bits equal to the loaded low bits plus k, modulo 4.
- R9: Bits 14..2 of `addr_o` do not change while a burst continues or is suspended.
- R10: After a deselect, `valid_o` stays 0 through any continue or suspend cycles until a new burst start.
- R11: In a continue or suspend cycle of an active block, `write_o` becomes NOT `wr_n_i` sampled in that same cycle.
- R12: The burst count wraps, so the fifth address of an unbroken burst equals the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 15 | External word address |
| start_cpu_n_i | input | 1 | Processor burst-start strobe, active low |
| start_ctl_n_i | input | 1 | Controller burst-start strobe, active low |
| adv_n_i | input | 1 | Burst advance strobe, active low |
| cs_n_i | input | 1 | Primary chip enable, active low |
| cs_hi_i | input | 1 | Chip enable, active high |
| cs2_n_i | input | 1 | Secondary chip enable, active low |
| wr_n_i | input | 1 | Combined write flag, active low |
| mode_i | input | 1 | Burst order: 1 interleaved, 0 linear (static) |
| addr_o | output | 15 | Internal word address |
| valid_o | output | 1 | A burst is active |
| write_o | output | 1 | Current access is a write |

## Verification
Both burst strobes can be low in the same cycle, and the primary enable then decides between them. With `cs_n_i` low the processor start must win and force a read. With `cs_n_i` high the controller strobe must deselect. Random stimulus drives both strobes low often and mixes in partial chip selects, so these collisions recur many times. Continue cycles are also driven onto a deselected block. A bench model, built from the priority order alone, judges `valid_o`, `write_o` and `addr_o` after every edge.

// File: rtl/bas_pkg.sv
package bas_pkg;
  localparam int unsigned ADDR_W  = 15;
  localparam int unsigned BURST_W = 2;

  typedef enum logic [2:0] {
    OP_DESEL    = 3'd0,
    OP_START_RD = 3'd1,
    OP_START_WR = 3'd2,
    OP_NEXT     = 3'd3,
    OP_HOLD     = 3'd4
  } bas_op_e;
endpackage

// File: rtl/bas_decode.sv
module bas_decode
  import bas_pkg::*;
(
  input  logic    start_cpu_n_i,
  input  logic    start_ctl_n_i,
  input  logic    adv_n_i,
  input  logic    cs_n_i,
  input  logic    cs_hi_i,
  input  logic    cs2_n_i,
  output bas_op_e op_o
);
  logic sel;
  assign sel = !cs_n_i && cs_hi_i && !cs2_n_i;

  // processor start outranks controller start, but only while cs_n_i is low
  always_comb begin
    if (!cs_n_i && !start_cpu_n_i)
      op_o = sel ? OP_START_RD : OP_DESEL;
    else if (!start_ctl_n_i)
      op_o = sel ? OP_START_WR : OP_DESEL;
    else
      op_o = adv_n_i ? OP_HOLD : OP_NEXT;
  end
endmodule

// File: rtl/bas_counter.sv
module bas_counter #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + CNT_ONE;
  end

  a_r12_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && cnt_o == '1) |=> cnt_o == '0);
endmodule

// File: rtl/bas_addr_gen.sv
module bas_addr_gen #(
  parameter int unsigned ADDR_W  = 15,
  parameter int unsigned BURST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BURST_W-1:0] cnt_i,
  input  logic              mode_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned HI_W = ADDR_W - BURST_W;

  logic [HI_W-1:0]    hi_q;
  logic [BURST_W-1:0] lo_q;
  logic [BURST_W-1:0] lo_xor, lo_add;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (load_i) begin
      hi_q <= addr_i[ADDR_W-1:BURST_W];
      lo_q <= addr_i[BURST_W-1:0];
    end
  end

  for (genvar b = 0; b < BURST_W; b++) begin : g_xor
    assign lo_xor[b] = lo_q[b] ^ cnt_i[b];
  end
  assign lo_add = lo_q + cnt_i;

  assign addr_o = {hi_q, mode_i ? lo_xor : lo_add};

  a_r9_hi_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> addr_o[ADDR_W-1:BURST_W] == $past(addr_o[ADDR_W-1:BURST_W]));
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bas_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned BW = BURST_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          start_cpu_n_i,
  input  logic          start_ctl_n_i,
  input  logic          adv_n_i,
  input  logic          cs_n_i,
  input  logic          cs_hi_i,
  input  logic          cs2_n_i,
  input  logic          wr_n_i,
  input  logic          mode_i,
  output logic [AW-1:0] addr_o,
  output logic          valid_o,
  output logic          write_o
);
  bas_op_e       op;
  logic          start;
  logic [BW-1:0] cnt;

  bas_decode u_dec (
    .start_cpu_n_i (start_cpu_n_i),
    .start_ctl_n_i (start_ctl_n_i),
    .adv_n_i       (adv_n_i),
    .cs_n_i        (cs_n_i),
    .cs_hi_i       (cs_hi_i),
    .cs2_n_i       (cs2_n_i),
    .op_o          (op)
  );

  assign start = (op == OP_START_RD) || (op == OP_START_WR);

  bas_counter #(.CNT_W(BW)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start),
    .inc_i  (valid_o && op == OP_NEXT),
    .cnt_o  (cnt)
  );

  bas_addr_gen #(.ADDR_W(AW), .BURST_W(BW)) u_agen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start),
    .addr_i (addr_i),
    .cnt_i  (cnt),
    .mode_i (mode_i),
    .addr_o (addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      write_o <= 1'b0;
    end else begin
      unique case (op)
        OP_DESEL:    begin valid_o <= 1'b0; write_o <= 1'b0;     end
        OP_START_RD: begin valid_o <= 1'b1; write_o <= 1'b0;     end
        OP_START_WR: begin valid_o <= 1'b1; write_o <= !wr_n_i;  end
        default:     if (valid_o) write_o <= !wr_n_i;
      endcase
    end
  end

  a_r3_cpu_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_i && !start_cpu_n_i && cs_hi_i && !cs2_n_i)
      |=> valid_o && !write_o && addr_o == $past(addr_i));

  a_r4_desel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_n_i && !start_ctl_n_i) |=> !valid_o && !write_o);

  a_r10_stay_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && start_ctl_n_i && (start_cpu_n_i || cs_n_i)) |=> !valid_o);

  a_r6_suspend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && start_ctl_n_i && (start_cpu_n_i || cs_n_i) && adv_n_i)
      |=> valid_o && addr_o == $past(addr_o));

  a_r11_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && start_ctl_n_i && (start_cpu_n_i || cs_n_i))
      |=> write_o == !$past(wr_n_i));
endmodule

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] addr = '0;
  logic        scpu_n = 1'b1, sctl_n = 1'b1, adv_n = 1'b1;
  logic        cs_n = 1'b1, cs_hi = 1'b0, cs2_n = 1'b1, wr_n = 1'b1, mode = 1'b1;
  logic [14:0] addr_o;
  logic        valid_o, write_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model
  bit        m_valid, m_wr;
  bit [14:0] m_base;
  bit [1:0]  m_cnt;

  always #5 clk = ~clk;

  burst_addr_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr),
    .start_cpu_n_i(scpu_n), .start_ctl_n_i(sctl_n), .adv_n_i(adv_n),
    .cs_n_i(cs_n), .cs_hi_i(cs_hi), .cs2_n_i(cs2_n), .wr_n_i(wr_n),
    .mode_i(mode), .addr_o(addr_o), .valid_o(valid_o), .write_o(write_o)
  );

  function automatic bit [14:0] exp_addr();
    bit [1:0] lo;
    lo = mode ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
    return {m_base[14:2], lo};
  endfunction

  function automatic void model_step();
    bit sel;
    sel = !cs_n && cs_hi && !cs2_n;
    if (!cs_n && !scpu_n) begin
      if (sel) begin m_valid = 1; m_wr = 0; m_base = addr; m_cnt = 0; end
      else begin m_valid = 0; m_wr = 0; end
    end else if (!sctl_n) begin
      if (sel) begin m_valid = 1; m_wr = !wr_n; m_base = addr; m_cnt = 0; end
      else begin m_valid = 0; m_wr = 0; end
    end else if (m_valid) begin
      if (!adv_n) m_cnt = m_cnt + 2'd1;
      m_wr = !wr_n;
    end
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_in(bit c_n, bit c_hi, bit c2_n, bit sp_n, bit sc_n,
                        bit a_n, bit w_n, bit [14:0] a);
    cs_n = c_n; cs_hi = c_hi; cs2_n = c2_n; scpu_n = sp_n; sctl_n = sc_n;
    adv_n = a_n; wr_n = w_n; addr = a;
  endtask

  // inputs already set at a negedge; clock them and compare at the next negedge
  task automatic step(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check({tag, " valid"}, 32'(valid_o), 32'(m_valid));
    check({tag, " write"}, 32'(write_o), 32'(m_wr));
    check({tag, " addr"},  32'(addr_o),  32'(exp_addr()));
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_valid = 0; m_wr = 0; m_base = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    check("R1 reset valid", 32'(valid_o), 32'd0);
    check("R1 reset write", 32'(write_o), 32'd0);
    check("R1 reset addr",  32'(addr_o),  32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: processor start with write flag low still reads, beats controller strobe
    set_in(0, 1, 0, 0, 0, 1, 0, 15'h1236);
    step("R3 cpu start");
    check("R3 read forced", 32'(write_o), 32'd0);
    check("R3 start addr", 32'(addr_o), 32'h1236);
    // R3: partial select with cpu strobe deselects
    set_in(0, 0, 0, 0, 1, 1, 1, 15'h0100);
    step("R3 partial");
    check("R3 partial desel", 32'(valid_o), 32'd0);
    // R10: continue cycles keep it off
    set_in(0, 1, 0, 1, 1, 0, 0, 15'h0);
    step("R10 cont");
    set_in(1, 1, 0, 0, 1, 0, 0, 15'h0);
    step("R4 cpu ignored cs_n high");
    check("R10 still off", 32'(valid_o), 32'd0);
    // R5/R2: controller write start
    set_in(0, 1, 0, 1, 0, 1, 0, 15'h7ff2);
    step("R5 ctl write");
    check("R5 write", 32'(write_o), 32'd1);
    // R7 + R6: interleaved 2,3,0,1 then wrap (R12); enables ignored
    set_in(1, 0, 1, 1, 1, 0, 0, 15'h0);
    step("R6 next");
    check("R7 k1", 32'(addr_o[1:0]), 32'd3);
    step("R7 k2");
    check("R7 k2 lo", 32'(addr_o[1:0]), 32'd0);
    check("R9 hi", 32'(addr_o[14:2]), 32'(15'h7ff2 >> 2));
    step("R7 k3");
    check("R7 k3 lo", 32'(addr_o[1:0]), 32'd1);
    step("R12 wrap");
    check("R12 wrap lo", 32'(addr_o[1:0]), 32'd2);
    // R6 suspend, R11 direction follows flag
    set_in(0, 0, 1, 1, 1, 1, 1, 15'h0);
    step("R6 hold");
    check("R6 hold addr", 32'(addr_o), 32'h7ff2);
    check("R11 dir", 32'(write_o), 32'd0);
    // R4: cs_n high with controller strobe deselects
    set_in(1, 1, 0, 1, 0, 1, 1, 15'h0);
    step("R4 desel");
    check("R4 desel valid", 32'(valid_o), 32'd0);
    // R8 linear from 3
    mode = 1'b0;
    set_in(0, 1, 0, 1, 0, 1, 1, 15'h0443);
    step("R8 start");
    set_in(0, 1, 0, 1, 1, 0, 1, 15'h0);
    step("R8 k1");
    check("R8 k1 lo", 32'(addr_o[1:0]), 32'd0);
    step("R8 k2");
    check("R8 k2 lo", 32'(addr_o[1:0]), 32'd1);
    // R2: controller start without full select
    set_in(0, 1, 1, 1, 0, 1, 0, 15'h0);
    step("R2 partial ctl");
    check("R2 desel", 32'(valid_o), 32'd0);

    // random phase
    for (int ph = 0; ph < 8; ph++) begin
      mode = ph[0];
      set_in(1, 0, 1, 1, 0, 1, 1, 15'h0);
      step("R4 phase desel");
      for (int i = 0; i < 400; i++) begin
        set_in($urandom_range(0, 3) == 0, $urandom_range(0, 4) != 0,
               $urandom_range(0, 4) == 0, $urandom_range(0, 5) != 0,
               $urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
               $urandom_range(0, 1) == 1, 15'($urandom));
        step("R6 R7 R8 R11 random");
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule